// File: doc/BRIEF.md
# Memory Power-Down Entry Timing Gate

This block sits beside the command issue logic of a DDR3-style memory controller. Every command the controller sends is also shown to the gate. The gate works out how long the memory needs before its clock-enable line may be pulled low, using the command kind, the burst mode and the configured latencies. It counts that wait down and raises `entry_ok` once the wait since the most recent command is over. A later command discards the countdown in progress and starts its own.

A power-down request from the controller's power policy is turned into the CKE level by a four-state machine. The states are `ST_UP_HOLD` (high, minimum high time still running), `ST_UP_FREE` (high, may fall), `ST_DN_HOLD` (low, minimum low time still running) and `ST_DN_FREE` (low, may rise). The transitions are:

- `UP_HOLD -> UP_FREE`: the high timer has expired and no entry is possible.
- `UP_HOLD -> DN_HOLD` or `UP_FREE -> DN_HOLD` ("enter"): the request is high, `entry_ok` is high, no command is issued in that cycle and the high minimum has been met.
- `DN_HOLD -> DN_FREE`: the low timer has expired while the request is still high.
- `DN_HOLD -> UP_HOLD` or `DN_FREE -> UP_HOLD` ("exit"): the request is low and the low minimum has been met.

A command strobed while CKE is low is reported on `proto_err` in the same cycle.

Top module: `pd_entry_gate`

## Requirements
- R1: Out of reset, `cke` is 1, `entry_ok` is 1 and `proto_err` is 0.
- R2: A command issued in cycle k loads a required wait D. `entry_ok` is 0 in cycles k+1 to k+D-1 and 1 from cycle k+D. Activate (`cmd_kind`=0), precharge (1) and refresh (6) have D = 1.
- R3: Read (2) and read with auto-precharge (3) have D = `rd_lat` + 5.
- R4: Write (4) has D = `wr_lat` + 4 + `wr_rec_cyc` when `chop4_fixed`=0 (fixed burst-8 or on-the-fly modes). It has D = `wr_lat` + 2 + `wr_rec_cyc` when `chop4_fixed`=1 (chop-4 fixed by mode register).
- R5: Write with auto-precharge (5) has D = `wr_lat` + 4 + `wr_mr` + 1 when `chop4_fixed`=0, and D = `wr_lat` + 2 + `wr_mr` + 1 when `chop4_fixed`=1.
- R6: Mode register set (7) has D = `mod_dly`; a `mod_dly` of 0 acts as 1.
- R7: A command issued while a wait is still running replaces that wait. `entry_ok` stays 0 and follows only the new command's D.
- R8: `cke` falls at the edge ending cycle j only when, in cycle j, `pd_req`=1, `entry_ok`=1 and `cmd_valid`=0, and `cke` has been high for at least CKE_MIN cycles. When all of this holds, it does fall.
- R9: Once low, `cke` stays low for at least PD_MIN cycles. It rises at the first edge after that at which `pd_req` was sampled 0.
- R10: `proto_err` is 1 exactly in cycles where `cmd_valid`=1 while `cke` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | Command code (0 act, 1 pre, 2 rd, 3 rda, 4 wr, 5 wra, 6 ref, 7 mrs) |
| chop4_fixed | input | 1 | Burst chop-4 is fixed by mode register |
| rd_lat | input | LAT_W | Read latency in cycles |
| wr_lat | input | LAT_W | Write latency in cycles |
| wr_rec_cyc | input | LAT_W | Write recovery time rounded up to whole cycles |
| wr_mr | input | LAT_W | Write recovery value programmed in the mode register |
| mod_dly | input | LAT_W | Mode-register-set to next command delay |
| pd_req | input | 1 | Power-down requested by the power policy |
| entry_ok | output | 1 | Wait since the last command has elapsed |
| cke | output | 1 | Clock-enable level toward the memory |
| proto_err | output | 1 | Command strobed while CKE is low |

## Verification
The bench builds the gate with LAT_W=5, PD_MIN=3 and CKE_MIN=4, and uses small latencies, so every command's wait resolves within about twenty cycles. These timer values let both CKE minimums be checked to the exact edge. A request that drops at once checks the low minimum, and a request held across the exit checks the high minimum. A command placed in the cycle where entry would otherwise happen checks the blocking rule. A mode delay of 0 and a write overtaken by a mode register set reach the floor and restart cases.

// File: rtl/pd_gate_pkg.sv
package pd_gate_pkg;

    typedef enum logic [2:0] {
        CMD_ACT = 3'd0,
        CMD_PRE = 3'd1,
        CMD_RD  = 3'd2,
        CMD_RDA = 3'd3,
        CMD_WR  = 3'd4,
        CMD_WRA = 3'd5,
        CMD_REF = 3'd6,
        CMD_MRS = 3'd7
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_UP_HOLD,
        ST_UP_FREE,
        ST_DN_HOLD,
        ST_DN_FREE
    } cke_state_e;

    // fixed cycle terms of the wait formulas
    localparam int unsigned RD_TAIL   = 5;
    localparam int unsigned BL8_TAIL  = 4;
    localparam int unsigned BC4_TAIL  = 2;
    localparam int unsigned AP_EXTRA  = 1;
    localparam int unsigned SHORT_WAIT = 1;

endpackage

// File: rtl/pd_delay_calc.sv
module pd_delay_calc
    import pd_gate_pkg::*;
#(
    parameter int LAT_W = 5,
    parameter int CNT_W = 7
) (
    input  logic [2:0]       cmd_kind,
    input  logic             chop4_fixed,
    input  logic [LAT_W-1:0] rd_lat,
    input  logic [LAT_W-1:0] wr_lat,
    input  logic [LAT_W-1:0] wr_rec_cyc,
    input  logic [LAT_W-1:0] wr_mr,
    input  logic [LAT_W-1:0] mod_dly,
    output logic [CNT_W-1:0] wait_cyc
);

    localparam int PAD = CNT_W - LAT_W;

    logic [CNT_W-1:0] rl_x, wl_x, wrc_x, wrmr_x, mod_x, burst_tail;
    cmd_kind_e        kind;

    assign rl_x   = {{PAD{1'b0}}, rd_lat};
    assign wl_x   = {{PAD{1'b0}}, wr_lat};
    assign wrc_x  = {{PAD{1'b0}}, wr_rec_cyc};
    assign wrmr_x = {{PAD{1'b0}}, wr_mr};
    assign mod_x  = {{PAD{1'b0}}, mod_dly};
    assign kind   = cmd_kind_e'(cmd_kind);

    // data beats after write latency: 2 cycles for fixed chop, else 4
    assign burst_tail = chop4_fixed ? CNT_W'(BC4_TAIL) : CNT_W'(BL8_TAIL);

    always_comb begin
        unique case (kind)
            CMD_ACT, CMD_PRE, CMD_REF: wait_cyc = CNT_W'(SHORT_WAIT);
            CMD_RD, CMD_RDA:           wait_cyc = rl_x + CNT_W'(RD_TAIL);
            CMD_WR:                    wait_cyc = wl_x + burst_tail + wrc_x;
            CMD_WRA:                   wait_cyc = wl_x + burst_tail + wrmr_x
                                                  + CNT_W'(AP_EXTRA);
            CMD_MRS:                   wait_cyc = (mod_x == '0) ? CNT_W'(SHORT_WAIT)
                                                                 : mod_x;
            default:                   wait_cyc = CNT_W'(SHORT_WAIT);
        endcase
    end

endmodule

// File: rtl/pd_countdown.sv
module pd_countdown #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             ready
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (load_val == '0) ? '0 : load_val - CNT_W'(1);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign ready = (remain == '0);

endmodule

// File: rtl/pd_cke_fsm.sv
module pd_cke_fsm
    import pd_gate_pkg::*;
#(
    parameter int PD_MIN  = 3,
    parameter int CKE_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic entry_ok,
    input  logic cmd_valid,
    output logic cke,
    output logic proto_err
);

    localparam int HOLD_MAX = (PD_MIN > CKE_MIN) ? PD_MIN : CKE_MIN;
    localparam int DW       = $clog2(HOLD_MAX + 1) + 1;
    localparam logic [DW-1:0] PD_LOAD  = DW'(PD_MIN - 1);
    localparam logic [DW-1:0] CKE_LOAD = DW'(CKE_MIN - 1);

    cke_state_e      state, state_nxt;
    logic [DW-1:0]   dwell, dwell_nxt;
    logic            go_down;

    assign go_down = pd_req && entry_ok && !cmd_valid;

    always_comb begin
        state_nxt = state;
        dwell_nxt = (dwell != '0) ? dwell - DW'(1) : dwell;
        unique case (state)
            ST_UP_HOLD: begin
                if (dwell == '0) begin
                    if (go_down) begin
                        state_nxt = ST_DN_HOLD;
                        dwell_nxt = PD_LOAD;
                    end else begin
                        state_nxt = ST_UP_FREE;
                    end
                end
            end
            ST_UP_FREE: begin
                if (go_down) begin
                    state_nxt = ST_DN_HOLD;
                    dwell_nxt = PD_LOAD;
                end
            end
            ST_DN_HOLD: begin
                if (dwell == '0) begin
                    if (!pd_req) begin
                        state_nxt = ST_UP_HOLD;
                        dwell_nxt = CKE_LOAD;
                    end else begin
                        state_nxt = ST_DN_FREE;
                    end
                end
            end
            ST_DN_FREE: begin
                if (!pd_req) begin
                    state_nxt = ST_UP_HOLD;
                    dwell_nxt = CKE_LOAD;
                end
            end
            default: begin
                state_nxt = ST_UP_FREE;
                dwell_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_UP_FREE;
            dwell <= '0;
        end else begin
            state <= state_nxt;
            dwell <= dwell_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ST_DN_HOLD, ST_DN_FREE: cke = 1'b0;
            default:                cke = 1'b1;
        endcase
        proto_err = cmd_valid && !cke;
    end

endmodule

// File: rtl/pd_entry_gate.sv
module pd_entry_gate #(
    parameter int LAT_W   = 5,
    parameter int PD_MIN  = 3,
    parameter int CKE_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_kind,
    input  logic             chop4_fixed,
    input  logic [LAT_W-1:0] rd_lat,
    input  logic [LAT_W-1:0] wr_lat,
    input  logic [LAT_W-1:0] wr_rec_cyc,
    input  logic [LAT_W-1:0] wr_mr,
    input  logic [LAT_W-1:0] mod_dly,
    input  logic             pd_req,
    output logic             entry_ok,
    output logic             cke,
    output logic             proto_err
);

    // widest wait: two latencies plus five fixed cycles
    localparam int CNT_W = LAT_W + 2;

    logic [CNT_W-1:0] wait_cyc;

    pd_delay_calc #(.LAT_W(LAT_W), .CNT_W(CNT_W)) calc_i (
        .cmd_kind    (cmd_kind),
        .chop4_fixed (chop4_fixed),
        .rd_lat      (rd_lat),
        .wr_lat      (wr_lat),
        .wr_rec_cyc  (wr_rec_cyc),
        .wr_mr       (wr_mr),
        .mod_dly     (mod_dly),
        .wait_cyc    (wait_cyc)
    );

    pd_countdown #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_valid),
        .load_val (wait_cyc),
        .ready    (entry_ok)
    );

    pd_cke_fsm #(.PD_MIN(PD_MIN), .CKE_MIN(CKE_MIN)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .entry_ok  (entry_ok),
        .cmd_valid (cmd_valid),
        .cke       (cke),
        .proto_err (proto_err)
    );

endmodule

// File: rtl/pd_gate_chk.sv
module pd_gate_chk
    import pd_gate_pkg::*;
#(
    parameter int PD_MIN  = 3,
    parameter int CKE_MIN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_kind,
    input logic       pd_req,
    input logic       entry_ok,
    input logic       cke
);

    logic [15:0] low_len, high_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_len  <= '0;
            high_len <= 16'(CKE_MIN);
        end else if (cke) begin
            low_len  <= '0;
            high_len <= (high_len == 16'hFFFF) ? high_len : high_len + 16'd1;
        end else begin
            high_len <= '0;
            low_len  <= (low_len == 16'hFFFF) ? low_len : low_len + 16'd1;
        end
    end

    // R9
    cke_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_len >= 16'(PD_MIN)));

    // R8
    cke_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (high_len >= 16'(CKE_MIN)));

    // R8
    cke_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(pd_req && entry_ok && !cmd_valid));

    // R9
    cke_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !$past(pd_req));

    // R3
    rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_kind == CMD_RD || cmd_kind == CMD_RDA)) |=> !entry_ok);

endmodule

bind pd_entry_gate pd_gate_chk #(.PD_MIN(PD_MIN), .CKE_MIN(CKE_MIN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .pd_req    (pd_req),
    .entry_ok  (entry_ok),
    .cke       (cke)
);

// File: tb/pd_entry_gate_tb_top.sv
module pd_entry_gate_tb_top;

    localparam int LAT_W   = 5;
    localparam int PD_MIN  = 3;
    localparam int CKE_MIN = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [2:0]       cmd_kind = 3'd0;
    logic             chop4_fixed = 1'b0;
    logic [LAT_W-1:0] rd_lat = 5'd6;
    logic [LAT_W-1:0] wr_lat = 5'd5;
    logic [LAT_W-1:0] wr_rec_cyc = 5'd7;
    logic [LAT_W-1:0] wr_mr = 5'd8;
    logic [LAT_W-1:0] mod_dly = 5'd12;
    logic             pd_req = 1'b0;
    logic             entry_ok, cke, proto_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pd_entry_gate #(.LAT_W(LAT_W), .PD_MIN(PD_MIN), .CKE_MIN(CKE_MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .chop4_fixed(chop4_fixed), .rd_lat(rd_lat), .wr_lat(wr_lat),
        .wr_rec_cyc(wr_rec_cyc), .wr_mr(wr_mr), .mod_dly(mod_dly),
        .pd_req(pd_req), .entry_ok(entry_ok), .cke(cke), .proto_err(proto_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_wait(input int k, input bit fx);
        int tail = fx ? 2 : 4;
        case (k)
            2, 3:    return int'(rd_lat) + 5;
            4:       return int'(wr_lat) + tail + int'(wr_rec_cyc);
            5:       return int'(wr_lat) + tail + int'(wr_mr) + 1;
            7:       return (mod_dly == 0) ? 1 : int'(mod_dly);
            default: return 1;
        endcase
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic smp();
        @(negedge clk);
    endtask

    task automatic push(input int k, input bit fx, input string tag);
        exp_q.push_back(exp_wait(k, fx));
        tag_q.push_back(tag);
    endtask

    task automatic issue(input int k, input bit fx, input string tag);
        push(k, fx, tag);
        cyc();
        cmd_valid   = 1'b1;
        cmd_kind    = 3'(k);
        chop4_fixed = fx;
        cyc();
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) cyc();
        cyc();
    endtask

    // monitor: measures cycles from each command to entry_ok
    initial begin
        int  cnt = 0;
        bit  pending = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (cmd_valid) begin
                    if (pending) begin
                        // R7: older wait discarded while entry still blocked
                        chk("R7", int'(entry_ok), 0);
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                    end
                    pending = 1'b1;
                    cnt = 0;
                end else if (pending) begin
                    cnt++;
                    if (entry_ok) begin
                        chk(tag_q.pop_front(), cnt, exp_q.pop_front());
                        pending = 1'b0;
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        smp();
        // R1 reset state
        chk("R1", int'(cke), 1);
        chk("R1", int'(entry_ok), 1);
        chk("R1", int'(proto_err), 0);

        // R2 short waits
        issue(0, 1'b0, "R2");
        drain();
        issue(1, 1'b0, "R2");
        drain();
        issue(6, 1'b0, "R2");
        drain();
        // R3 reads
        issue(2, 1'b0, "R3");
        drain();
        issue(3, 1'b1, "R3");
        drain();
        // R4 writes in both burst modes
        issue(4, 1'b0, "R4");
        drain();
        issue(4, 1'b1, "R4");
        drain();
        // R5 writes with auto-precharge
        issue(5, 1'b0, "R5");
        drain();
        issue(5, 1'b1, "R5");
        drain();
        // R6 mode register set, normal and floor
        issue(7, 1'b0, "R6");
        drain();
        mod_dly = 5'd0;
        issue(7, 1'b0, "R6");
        drain();
        mod_dly = 5'd12;

        // R7 write overtaken by mode register set
        push(4, 1'b0, "R7");
        cyc(); cmd_valid = 1'b1; cmd_kind = 3'd4; chop4_fixed = 1'b0;
        cyc(); cmd_valid = 1'b0;
        cyc();
        push(7, 1'b0, "R7");
        cyc(); cmd_valid = 1'b1; cmd_kind = 3'd7;
        cyc(); cmd_valid = 1'b0;
        drain();
        repeat (6) cyc();

        // R8/R9 entry and minimum low time
        cyc(); pd_req = 1'b1; smp(); chk("R8", int'(cke), 1);
        cyc(); pd_req = 1'b0; smp(); chk("R8", int'(cke), 0);
        cyc(); smp(); chk("R9", int'(cke), 0);
        cyc(); smp(); chk("R9", int'(cke), 0);
        cyc(); pd_req = 1'b1; smp(); chk("R9", int'(cke), 1);
        // R8 minimum high time
        cyc(); smp();
        cyc(); smp();
        cyc(); smp(); chk("R8", int'(cke), 1);
        cyc(); smp(); chk("R8", int'(cke), 0);
        // R10 command while low
        push(2, 1'b0, "R3");
        cyc(); cmd_valid = 1'b1; cmd_kind = 3'd2; smp();
        chk("R10", int'(proto_err), 1);
        cyc(); cmd_valid = 1'b0; pd_req = 1'b0; smp();
        chk("R10", int'(proto_err), 0);
        chk("R9", int'(cke), 0);
        cyc(); pd_req = 1'b1; smp();
        chk("R9", int'(cke), 1);
        chk("R8", int'(entry_ok), 0);
        // R8 entry waits for entry_ok
        for (int i = 0; i < 40 && !entry_ok; i++) smp();
        chk("R8", int'(cke), 1);
        smp();
        chk("R8", int'(cke), 0);
        cyc(); pd_req = 1'b0;
        for (int i = 0; i < 10 && !cke; i++) smp();
        chk("R9", int'(cke), 1);
        repeat (6) cyc();

        // R8 command in the entry cycle blocks the fall
        push(0, 1'b0, "R2");
        cyc(); pd_req = 1'b1; cmd_valid = 1'b1; cmd_kind = 3'd0; smp();
        chk("R8", int'(cke), 1);
        cyc(); cmd_valid = 1'b0; smp();
        chk("R8", int'(cke), 1);
        cyc(); smp();
        chk("R8", int'(cke), 0);
        cyc(); pd_req = 1'b0;
        repeat (8) cyc();
        chk("R2", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule